// File: doc/BRIEF.md
# Bit-Clock Paced Transmit Serializer

This block sits on the host side of a link to an RF transceiver whose internal encoder pulls transmit bits one at a time. The transceiver owns the bit clock, and the block only follows it. Software or an upstream engine loads a word count and picks a word width: 8 bits, or 9 bits when each word carries a parity bit. The block then takes words through a valid/ready port and drives a transmit-enable line and a transmit-data line, changing the data line only in step with the remote clock.

The bit clock and the interrupt line reach the block asynchronously. Both are synchronized into the system clock before the block looks for edges. At the end of a frame the block runs a fixed closing handshake on the bit clock and then pulses `done`. If the interrupt line rises, the link stalls past a cycle limit, or the word source falls behind the bit clock, the block drops both lines and pulses `abort_flag`.

Top module: `bitclk_tx_serializer`

## Requirements
- R1: After reset and whenever idle, `tx_en`, `tx_data`, `in_ready`, `done` and `abort_flag` are all low.
- R2: A `start` with a nonzero `word_count` makes the block accept one word. It drives that word's bit 0 onto `tx_data` and raises `tx_en` one cycle later, with `tx_data` unchanged in the cycle `tx_en` rises.
- R3: While enabled, `tx_data` changes only in response to a detected rising edge of the bit clock. Each value is therefore stable across the following falling edge, where the transceiver latches it.
- R4: Words are sent in arrival order and least significant bit first. `wide_sel`=0 sends `in_data[7:0]`, and `wide_sel`=1 sends `in_data[8:0]`. Exactly `word_count` words are sent.
- R5: After the falling edge that latches the last bit of a word that is not the final word, the block raises `in_ready` for the next word. If a rising bit-clock edge arrives before that word, the frame aborts.
- R6: `tx_en` falls, and `tx_data` goes low, on the rising bit-clock edge that follows the falling edge latching the final bit. It does not fall earlier.
- R7: After `tx_en` falls, the block waits for one more falling edge and then one more rising edge. It then pulses `done` for exactly one cycle and returns to idle.
- R8: A high `irq_in` during any bit-clock wait aborts the frame. `tx_en` and `tx_data` drop and `abort_flag` pulses for one cycle.
- R9: If no bit-clock edge arrives within `TMO_CYC` system cycles during a bit-clock wait, the frame aborts as in R8.
- R10: `start` is ignored while a frame is in progress, and also when `word_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (one-cycle pulse) |
| word_count | input | CNT_W | Number of words in the frame, sampled at start |
| wide_sel | input | 1 | 0: 8-bit words, 1: 9-bit words, sampled at start |
| in_valid | input | 1 | Word source has a word |
| in_data | input | 9 | Word, LSB sent first |
| in_ready | output | 1 | Block takes the word this cycle if valid |
| bclk_in | input | 1 | Asynchronous bit clock from the transceiver |
| irq_in | input | 1 | Asynchronous interrupt from the transceiver |
| tx_en | output | 1 | Transmit enable to the transceiver |
| tx_data | output | 1 | Transmit data to the transceiver |
| done | output | 1 | One-cycle pulse when the closing sequence ends |
| abort_flag | output | 1 | One-cycle pulse when a frame is abandoned |

## Verification
The bench acts as the transceiver and sweeps both word widths across frames of one to three words. It captures `tx_data` just before each falling edge and rebuilds the words. A bit-order or width error shows up as a wrong word, and presenting data on the wrong edge shifts every bit by one position. The closing sequence is checked edge by edge. A design that dropped enable too early, or pulsed `done` before the last rising edge, would be caught. Interrupt, stalled-clock and starved-source frames must each end in an abort with both lines low. A second `start` in mid-frame, and a `start` with a zero count, must change nothing.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int unsigned WORD_W = 9;
    localparam int unsigned BIDX_W = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH_FIRST,
        ST_PLACE,
        ST_ENABLE,
        ST_WFALL,
        ST_FETCH_NEXT,
        ST_WRISE,
        ST_TAIL_F,
        ST_TAIL_R
    } tx_state_e;

    // index of the last bit in a word for the selected width
    function automatic logic [BIDX_W-1:0] last_bit_idx(input logic wide);
        return wide ? BIDX_W'(WORD_W - 1) : BIDX_W'(WORD_W - 2);
    endfunction

    // states in which the block waits on the remote bit clock
    function automatic logic is_edge_wait(input tx_state_e s);
        return (s == ST_WFALL) || (s == ST_WRISE) || (s == ST_FETCH_NEXT) ||
               (s == ST_TAIL_F) || (s == ST_TAIL_R);
    endfunction

endpackage

// File: rtl/sertx_sync.sv
module sertx_sync #(
    parameter int unsigned N      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], async_in[g]};
        end
        assign sync_out[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/sertx_watchdog.sv
module sertx_watchdog #(
    parameter int unsigned TMO_CYC = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic kick,
    output logic expired
);
    localparam int unsigned CW = $clog2(TMO_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TMO_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active || kick) cnt <= '0;
        else if (cnt != LIMIT)      cnt <= cnt + 1'b1;
    end

    assign expired = active && !kick && (cnt == LIMIT);
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] word,
    input  logic         pop,
    output logic         head
);
    logic [W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst)       sreg <= '0;
        else if (load) sreg <= word;
        else if (pop)  sreg <= {1'b0, sreg[W-1:1]};
    end

    assign head = sreg[0];
endmodule

// File: rtl/bitclk_tx_serializer.sv
module bitclk_tx_serializer
    import sertx_pkg::*;
#(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned TMO_CYC     = 1024,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  word_count,
    input  logic              wide_sel,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    input  logic              bclk_in,
    input  logic              irq_in,
    output logic              tx_en,
    output logic              tx_data,
    output logic              done,
    output logic              abort_flag
);
    localparam int unsigned NSYNC = 2;

    tx_state_e          st;
    logic [NSYNC-1:0]   sync_v;
    logic               bclk_s, irq_s, bclk_prev;
    logic               edge_rise, edge_fall;
    logic               tmo_hit, waiting, abort_now;
    logic               wide_q, fresh, final_bit, load, pop, head;
    logic [CNT_W-1:0]   words_left;
    logic [BIDX_W-1:0]  bit_idx, width_m1;

    sertx_sync #(.N(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in({irq_in, bclk_in}), .sync_out(sync_v)
    );
    assign bclk_s = sync_v[0];
    assign irq_s  = sync_v[1];

    always_ff @(posedge clk) begin
        if (rst) bclk_prev <= 1'b0;
        else     bclk_prev <= bclk_s;
    end
    assign edge_rise = bclk_s & ~bclk_prev;
    assign edge_fall = ~bclk_s & bclk_prev;

    assign waiting = is_edge_wait(st);

    sertx_watchdog #(.TMO_CYC(TMO_CYC)) u_wd (
        .clk(clk), .rst(rst), .active(waiting),
        .kick(edge_rise | edge_fall), .expired(tmo_hit)
    );

    assign abort_now = waiting && (irq_s || tmo_hit ||
                                   (st == ST_FETCH_NEXT && edge_rise));

    assign width_m1  = last_bit_idx(wide_q);
    assign final_bit = !fresh && (bit_idx == width_m1) && (words_left == '0);

    assign in_ready = (st == ST_FETCH_FIRST) || (st == ST_FETCH_NEXT && !abort_now);
    assign load     = in_ready && in_valid;
    assign pop      = (st == ST_PLACE) || (st == ST_WRISE && edge_rise && !final_bit && !abort_now);

    sertx_shift #(.W(WORD_W)) u_shift (
        .clk(clk), .rst(rst), .load(load), .word(in_data), .pop(pop), .head(head)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            tx_en      <= 1'b0;
            tx_data    <= 1'b0;
            done       <= 1'b0;
            abort_flag <= 1'b0;
            wide_q     <= 1'b0;
            fresh      <= 1'b0;
            words_left <= '0;
            bit_idx    <= '0;
        end else begin
            done       <= 1'b0;
            abort_flag <= 1'b0;
            if (abort_now) begin
                tx_en      <= 1'b0;
                tx_data    <= 1'b0;
                abort_flag <= 1'b1;
                st         <= ST_IDLE;
            end else begin
                unique case (st)
                    ST_IDLE: begin
                        if (start && word_count != '0) begin
                            wide_q     <= wide_sel;
                            words_left <= word_count - 1'b1;
                            st         <= ST_FETCH_FIRST;
                        end
                    end
                    ST_FETCH_FIRST: begin
                        if (in_valid) begin
                            bit_idx <= '0;
                            fresh   <= 1'b0;
                            st      <= ST_PLACE;
                        end
                    end
                    ST_PLACE: begin
                        tx_data <= head;
                        st      <= ST_ENABLE;
                    end
                    ST_ENABLE: begin
                        tx_en <= 1'b1;
                        st    <= ST_WFALL;
                    end
                    ST_WFALL: begin
                        if (edge_fall)
                            st <= (bit_idx == width_m1 && words_left != '0) ?
                                  ST_FETCH_NEXT : ST_WRISE;
                    end
                    ST_FETCH_NEXT: begin
                        if (in_valid) begin
                            words_left <= words_left - 1'b1;
                            bit_idx    <= '0;
                            fresh      <= 1'b1;
                            st         <= ST_WRISE;
                        end
                    end
                    ST_WRISE: begin
                        if (edge_rise) begin
                            if (final_bit) begin
                                tx_en   <= 1'b0;
                                tx_data <= 1'b0;
                                st      <= ST_TAIL_F;
                            end else begin
                                tx_data <= head;
                                if (fresh) fresh   <= 1'b0;
                                else       bit_idx <= bit_idx + 1'b1;
                                st <= ST_WFALL;
                            end
                        end
                    end
                    ST_TAIL_F: if (edge_fall) st <= ST_TAIL_R;
                    ST_TAIL_R: begin
                        if (edge_rise) begin
                            done <= 1'b1;
                            st   <= ST_IDLE;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // R2: enable rises onto data that was already in place
    assert_data_before_enable_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> $stable(tx_data));

    // R3: while enabled, data moves only after a detected rising bit-clock edge
    assert_data_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_en && $past(tx_en) && !$stable(tx_data)) |-> $past(edge_rise));

    // R6: a regular (non-abort) enable drop follows a rising bit-clock edge
    assert_enable_drop_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(tx_en) && !abort_flag) |-> $past(edge_rise));

    // R7: completion only with enable low and no abort
    assert_done_clean_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!tx_en && !tx_data && !abort_flag));

    // R8: an abort always leaves both lines low
    assert_abort_lines_low_R8: assert property (@(posedge clk) disable iff (rst)
        abort_flag |-> (!tx_en && !tx_data));

    // R1: no word is taken while enable is low, except for the first word of a frame
    assert_ready_scope_R1: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !tx_en) |-> !$past(tx_en));
endmodule

// File: tb/tb_bitclk_tx_serializer.sv
module tb_bitclk_tx_serializer;
    localparam int TMO = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] word_count = '0;
    logic       wide_sel = 1'b0;
    logic       in_valid = 1'b0;
    logic [8:0] in_data = '0;
    logic       in_ready;
    logic       bclk_in = 1'b1;
    logic       irq_in = 1'b0;
    logic       tx_en, tx_data, done, abort_flag;

    int tests = 0;
    int fails = 0;
    int done_cnt = 0;
    int abort_cnt = 0;
    logic [8:0] wq [0:7];
    bit got [0:31];

    always #4 clk = ~clk;

    bitclk_tx_serializer #(.CNT_W(8), .TMO_CYC(TMO), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .start(start), .word_count(word_count),
        .wide_sel(wide_sel), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .bclk_in(bclk_in), .irq_in(irq_in),
        .tx_en(tx_en), .tx_data(tx_data), .done(done), .abort_flag(abort_flag)
    );

    always @(negedge clk) begin
        if (done)       done_cnt++;
        if (abort_flag) abort_cnt++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start(input int cnt, input bit wide);
        @(negedge clk);
        word_count = 8'(cnt);
        wide_sel   = wide;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic feed(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = wq[i];
            do @(posedge clk); while (!in_ready);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_enable();
        for (int i = 0; i < 40; i++) begin
            if (tx_en) break;
            @(negedge clk);
        end
    endtask

    // one bit period as the transceiver: latch on fall, request on rise
    task automatic clk_bit(output bit b, output bit en);
        wait_n(6);
        b  = tx_data;
        en = tx_en;
        bclk_in = 1'b0;
        wait_n(6);
        bclk_in = 1'b1;
        wait_n(6);
    endtask

    task automatic do_frame(input int cnt, input bit wide, input bit restart);
        int  w, d0, a0;
        bit  b, en, all_en;
        w  = wide ? 9 : 8;
        d0 = done_cnt;
        a0 = abort_cnt;
        for (int i = 0; i < cnt; i++)
            wq[i] = 9'((i * 167 + cnt * 53 + (wide ? 301 : 27)) % 512);
        fork
            feed(cnt);
            begin
                pulse_start(cnt, wide);
                wait_enable();
                chk(tx_en == 1'b1, "R2 enable raised", int'(tx_en), 1);
                chk(tx_data == wq[0][0], "R2 first bit placed", int'(tx_data), int'(wq[0][0]));
                all_en = 1'b1;
                for (int k = 0; k < cnt * w; k++) begin
                    if (restart && k == 3) begin
                        @(negedge clk);
                        word_count = 8'd5;
                        start = 1'b1;
                        @(negedge clk);
                        start = 1'b0;
                    end
                    clk_bit(b, en);
                    got[k] = b;
                    all_en &= en;
                end
            end
        join
        chk(all_en, "R3 enable held through data bits", int'(all_en), 1);
        chk(tx_en == 1'b0 && tx_data == 1'b0, "R6 enable dropped after last rise",
            int'({tx_en, tx_data}), 0);
        for (int i = 0; i < cnt; i++) begin
            int rw = 0;
            int ew = int'(wq[i]) & (wide ? 511 : 255);
            for (int j = 0; j < w; j++) rw |= int'(got[i * w + j]) << j;
            chk(rw == ew, "R4 word content LSB first", rw, ew);
        end
        bclk_in = 1'b0;
        wait_n(6);
        chk(done_cnt == d0, "R7 no done before closing rise", done_cnt - d0, 0);
        bclk_in = 1'b1;
        wait_n(8);
        chk(done_cnt == d0 + 1, "R7 done pulsed once", done_cnt - d0, 1);
        chk(abort_cnt == a0, "R7 no abort on clean frame", abort_cnt - a0, 0);
        chk(tx_en == 1'b0 && tx_data == 1'b0 && in_ready == 1'b0, "R1 idle after frame",
            int'({tx_en, tx_data, in_ready}), 0);
        if (restart)
            chk(cnt == 1 && done_cnt == d0 + 1, "R10 restart ignored mid-frame", cnt, 1);
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        bit b, en;
        int a0, d0;
        wait_n(4);
        rst = 1'b0;
        wait_n(6);
        chk({tx_en, tx_data, in_ready, done, abort_flag} == 5'b0, "R1 reset state",
            int'({tx_en, tx_data, in_ready, done, abort_flag}), 0);

        // sweep both widths across small word counts (R4, R5)
        for (int wd = 0; wd < 2; wd++)
            for (int c = 1; c <= 3; c++)
                do_frame(c, wd[0], 1'b0);

        // R10: start in mid-frame
        do_frame(1, 1'b0, 1'b1);

        // R10: zero count is ignored
        d0 = done_cnt;
        pulse_start(0, 1'b0);
        wait_n(20);
        chk(tx_en == 1'b0 && in_ready == 1'b0 && done_cnt == d0, "R10 zero count ignored",
            int'({tx_en, in_ready}), 0);

        // R8: interrupt aborts mid-word
        a0 = abort_cnt;
        wq[0] = 9'h1FF;
        fork
            feed(1);
            begin
                pulse_start(1, 1'b1);
                wait_enable();
                for (int k = 0; k < 3; k++) clk_bit(b, en);
            end
        join
        irq_in = 1'b1;
        wait_n(8);
        chk(abort_cnt == a0 + 1, "R8 interrupt abort pulsed", abort_cnt - a0, 1);
        chk(tx_en == 1'b0 && tx_data == 1'b0, "R8 lines low after abort",
            int'({tx_en, tx_data}), 0);
        irq_in = 1'b0;
        wait_n(8);

        // R9: stalled bit clock times out
        a0 = abort_cnt;
        wq[0] = 9'h0A5;
        fork
            feed(1);
            begin
                pulse_start(1, 1'b0);
                wait_enable();
            end
        join
        wait_n(TMO - 10);
        chk(abort_cnt == a0 && tx_en == 1'b1, "R9 no early timeout", abort_cnt - a0, 0);
        wait_n(30);
        chk(abort_cnt == a0 + 1, "R9 timeout abort", abort_cnt - a0, 1);
        chk(tx_en == 1'b0, "R9 enable low after timeout", int'(tx_en), 0);

        // R5: second word missing at the next rising edge
        a0 = abort_cnt;
        wq[0] = 9'h03C;
        fork
            feed(1);
            begin
                pulse_start(2, 1'b0);
                wait_enable();
                for (int k = 0; k < 7; k++) clk_bit(b, en);
                wait_n(6);
                bclk_in = 1'b0;
                wait_n(6);
                chk(in_ready == 1'b1, "R5 ready for next word", int'(in_ready), 1);
                bclk_in = 1'b1;
                wait_n(8);
            end
        join
        chk(abort_cnt == a0 + 1, "R5 underrun abort", abort_cnt - a0, 1);
        chk(tx_en == 1'b0 && tx_data == 1'b0, "R5 lines low after underrun",
            int'({tx_en, tx_data}), 0);

        // back to normal after aborts
        do_frame(2, 1'b1, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule